// File: doc/BRIEF.md
# Multi-Vector Port Interrupt Aggregator

This block gathers the interrupt state of a storage host controller with up to 32 ports and turns it into host interrupts. Each port holds a status word, which hardware sets through a per-port event strobe and software clears by writing ones, and an enable word. A global summary register keeps one bit per port, and a global enable bit gates all signalling. The block signals the host either on a level-sensitive legacy line (when built with zero message vectors) or as one-cycle message pulses that carry a vector index.

When there are fewer message vectors than ports, the lowest ports each get a vector of their own and all remaining ports share the top vector. A dedicated vector fires on every qualifying event. The shared vector, like the legacy line, fires only when a port's summary bit goes from 0 to 1. Writes to the global status or control register re-evaluate every vector against the written mask. Several vectors can qualify in the same cycle, so they are held in a pending set and sent one per cycle, lowest index first.

Top module: `hba_irq_agg`

## Requirements
- R1: Summary bit i is set when port i's check runs and its status word ANDed with its enable word is nonzero. A port whose enable word masks its status leaves the summary unchanged.
- R2: With NUM_VEC vectors and NUM_PORTS ports, port i uses vector i when NUM_PORTS <= NUM_VEC or i < NUM_VEC-1. Every other port uses vector NUM_VEC-1.
- R3: An event strobe ORs its bits into the port status word. The port check runs only if at least one strobed bit was not already set, so a repeated event emits nothing.
- R4: For a port with a dedicated vector, each check that finds the port pending sets its summary bit and, with global enable on, emits that port's vector, even when the summary bit was already set.
- R5: For a port on the shared vector, a check that finds the port pending does nothing if its summary bit is already 1. Otherwise it sets the bit and, with global enable on, emits vector NUM_VEC-1.
- R6: Word address 2+2i is port i's status (writing 1s clears those bits). Word address 3+2i is port i's enable, stored as the written value ANDed with 0xFDC000FF. A write to either re-runs that port's check.
- R7: Word address 1 is the summary (write 1s to clear). A write clears those bits, merges back every still-pending port, and, if summary AND mask is nonzero, emits each vector whose set of ports overlaps the mask.
- R8: Word address 0 is control. A write with bit 0 set performs a host reset: it clears all status, enable and summary words, the global enable, the legacy line and any pending vectors, and does nothing else. Any other write loads global enable from bit 1 and re-evaluates as in R7 with an all-ones mask and no clearing.
- R9: With NUM_VEC = 0, the legacy line is asserted when a port check sets a summary bit with global enable on, or when a re-evaluation finds a nonzero summary with global enable on. The line drops only when a re-evaluation finds a zero summary or global enable off.
- R10: Vectors that qualify together are all sent, one per cycle, on msg_valid/msg_index in ascending index order.
- R11: Reads have no side effects and return the stored words. The control word reads back global enable in bit 1 and, in bits 12:8, the advertised vector count: NUM_PORTS capped at 16 and rounded up to a power of two.
- R12: With global enable off, checks still update the summary but no vector is emitted and the legacy line is not asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| evt_stb | input | NUM_PORTS | Per-port event strobe |
| evt_bits | input | 32*NUM_PORTS | Status bits raised by each port, port i at [32i+31:32i] |
| legacy_irq | output | 1 | Level interrupt line (used when NUM_VEC = 0) |
| msg_valid | output | 1 | One-cycle message pulse |
| msg_index | output | 4 | Vector index of the message |

## Verification
A six-port, four-vector instance is driven with four kinds of traffic. Repeated and fresh events on a dedicated port show that only new status bits trigger a check. Events on two ports behind the shared vector show the edge-only rule apart from the every-event rule of dedicated vectors. Global status writes with narrow and wide masks, and control writes that toggle the enable, show how the mask selects vectors and that the pending set drains in ascending order. A two-port instance without vectors checks when the legacy line rises, that clearing a port status alone does not drop it, and that a summary clear does.

// File: rtl/hba_irq_pkg.sv
package hba_irq_pkg;

    localparam int REG_W        = 32;
    localparam int MAX_VEC      = 16;
    localparam int VEC_IDX_W    = 4;
    localparam int CTRL_RST_BIT = 0;
    localparam int CTRL_IE_BIT  = 1;
    localparam int CTRL_ADV_LSB = 8;
    localparam logic [REG_W-1:0] PORT_IE_WMASK = 32'hFDC0_00FF;

    typedef enum logic [1:0] {
        REG_CTRL,
        REG_SUM,
        REG_PSTAT,
        REG_PEN
    } reg_kind_e;

    typedef struct packed {
        logic      hit;
        reg_kind_e kind;
        logic [7:0] port;
    } reg_dec_t;

    // Vector count offered to the host: ports capped at MAX_VEC, rounded up to 2^k
    function automatic int adv_vec_count(int ports);
        int c;
        int p;
        c = (ports > MAX_VEC) ? MAX_VEC : ports;
        p = 1;
        while (p < c) p = p * 2;
        return p;
    endfunction

    function automatic logic has_own_vec(int port, int ports, int nvec);
        return (nvec > 0) && ((ports <= nvec) || (port < nvec - 1));
    endfunction

    function automatic int vec_of_port(int port, int ports, int nvec);
        return has_own_vec(port, ports, nvec) ? port : nvec - 1;
    endfunction

    function automatic reg_dec_t decode_addr(logic [31:0] a, int ports);
        reg_dec_t d;
        int p;
        d.hit  = 1'b0;
        d.kind = REG_CTRL;
        d.port = '0;
        if (a == 32'd0) begin
            d.hit = 1'b1;
        end else if (a == 32'd1) begin
            d.hit  = 1'b1;
            d.kind = REG_SUM;
        end else begin
            p = int'((a - 32'd2) >> 1);
            if (p < ports) begin
                d.hit  = 1'b1;
                d.port = 8'(p);
                d.kind = a[0] ? REG_PEN : REG_PSTAT;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/hba_port_regs.sv
module hba_port_regs
    import hba_irq_pkg::*;
#(
    parameter int NUM_PORTS = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_PORTS-1:0]       evt_stb,
    input  logic [NUM_PORTS*REG_W-1:0] evt_bits,
    input  logic [NUM_PORTS-1:0]       stat_we,
    input  logic [NUM_PORTS-1:0]       en_we,
    input  logic [REG_W-1:0]           wdata,
    output logic [NUM_PORTS*REG_W-1:0] stat_flat,
    output logic [NUM_PORTS*REG_W-1:0] en_flat,
    output logic [NUM_PORTS-1:0]       pend_nx,
    output logic [NUM_PORTS-1:0]       pend_now,
    output logic [NUM_PORTS-1:0]       run_chk
);

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        logic [REG_W-1:0] stat_r, en_r;
        logic [REG_W-1:0] clr, raised, fresh, stat_n, en_n;

        always_comb begin
            clr    = stat_we[i] ? wdata : '0;
            raised = evt_stb[i] ? evt_bits[i*REG_W +: REG_W] : '0;
            fresh  = raised & ~(stat_r & ~clr);
            stat_n = (stat_r & ~clr) | raised;
            en_n   = en_we[i] ? (wdata & PORT_IE_WMASK) : en_r;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                stat_r <= '0;
                en_r   <= '0;
            end else begin
                stat_r <= stat_n;
                en_r   <= en_n;
            end
        end

        assign run_chk[i]  = (|fresh) | stat_we[i] | en_we[i];
        assign pend_nx[i]  = |(stat_n & en_n);
        assign pend_now[i] = |(stat_r & en_r);
        assign stat_flat[i*REG_W +: REG_W] = stat_r;
        assign en_flat[i*REG_W +: REG_W]   = en_r;
    end

endmodule

// File: rtl/hba_vec_queue.sv
module hba_vec_queue
    import hba_irq_pkg::*;
#(
    parameter int NUM_VEC = 4,
    localparam int FV_W = (NUM_VEC > 0) ? NUM_VEC : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [FV_W-1:0]      fire_in,
    output logic                 msg_valid,
    output logic [VEC_IDX_W-1:0] msg_index
);

    if (NUM_VEC > 0) begin : g_queue
        logic [NUM_VEC-1:0] pend_q, grant;

        always_comb begin
            grant     = '0;
            msg_index = '0;
            for (int v = NUM_VEC - 1; v >= 0; v--) begin
                if (pend_q[v]) begin
                    grant     = '0;
                    grant[v]  = 1'b1;
                    msg_index = VEC_IDX_W'(v);
                end
            end
        end

        assign msg_valid = |pend_q;

        always_ff @(posedge clk) begin
            if (rst) pend_q <= '0;
            else     pend_q <= (pend_q & ~grant) | fire_in;
        end

        // R10
        ascend_order_chk: assert property (@(posedge clk) disable iff (rst)
            (msg_valid && $past(msg_valid) && ($past(fire_in) == '0) && !$past(rst))
            |-> (msg_index > $past(msg_index)));

        // R10
        fire_lands_chk: assert property (@(posedge clk) disable iff (rst)
            (fire_in != '0) |=> msg_valid);
    end else begin : g_none
        assign msg_valid = 1'b0;
        assign msg_index = '0;
    end

endmodule

// File: rtl/hba_irq_agg.sv
module hba_irq_agg
    import hba_irq_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter int NUM_VEC   = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [REG_W-1:0]           bus_wdata,
    input  logic                       bus_we,
    output logic [REG_W-1:0]           bus_rdata,
    input  logic [NUM_PORTS-1:0]       evt_stb,
    input  logic [NUM_PORTS*REG_W-1:0] evt_bits,
    output logic                       legacy_irq,
    output logic                       msg_valid,
    output logic [VEC_IDX_W-1:0]       msg_index
);

    localparam int FV_W = (NUM_VEC > 0) ? NUM_VEC : 1;
    localparam int ADV  = adv_vec_count(NUM_PORTS);

    function automatic logic [NUM_PORTS-1:0] cover_mask(int v);
        logic [NUM_PORTS-1:0] m;
        for (int p = 0; p < NUM_PORTS; p++)
            m[p] = (NUM_VEC > 0) && (vec_of_port(p, NUM_PORTS, NUM_VEC) == v);
        return m;
    endfunction

    reg_dec_t dec;
    logic ctrl_wr, host_rst, ctrl_load, sum_wr, blk_rst;
    logic [NUM_PORTS-1:0] stat_we, en_we, pend_nx, pend_now, run_chk;
    logic [NUM_PORTS*REG_W-1:0] stat_flat, en_flat;

    logic                 gie_q, gie_n, legacy_q, legacy_n;
    logic [NUM_PORTS-1:0] sum_q, sum_n, sum_base, gmask;
    logic [FV_W-1:0]      fire_vec;
    logic                 leg_set, leg_clr, reeval;

    assign dec       = decode_addr(32'(bus_addr), NUM_PORTS);
    assign ctrl_wr   = bus_we && dec.hit && (dec.kind == REG_CTRL);
    assign host_rst  = ctrl_wr && bus_wdata[CTRL_RST_BIT];
    assign ctrl_load = ctrl_wr && !bus_wdata[CTRL_RST_BIT];
    assign sum_wr    = bus_we && dec.hit && (dec.kind == REG_SUM);
    assign blk_rst   = rst || host_rst;

    always_comb begin
        for (int i = 0; i < NUM_PORTS; i++) begin
            stat_we[i] = bus_we && dec.hit && (dec.kind == REG_PSTAT) && (dec.port == 8'(i));
            en_we[i]   = bus_we && dec.hit && (dec.kind == REG_PEN)   && (dec.port == 8'(i));
        end
    end

    hba_port_regs #(.NUM_PORTS(NUM_PORTS)) u_ports (
        .clk      (clk),
        .rst      (blk_rst),
        .evt_stb  (evt_stb),
        .evt_bits (evt_bits),
        .stat_we  (stat_we),
        .en_we    (en_we),
        .wdata    (bus_wdata),
        .stat_flat(stat_flat),
        .en_flat  (en_flat),
        .pend_nx  (pend_nx),
        .pend_now (pend_now),
        .run_chk  (run_chk)
    );

    // Port checks, then global re-evaluation on summary/control writes
    always_comb begin
        gie_n    = ctrl_load ? bus_wdata[CTRL_IE_BIT] : gie_q;
        reeval   = sum_wr || ctrl_load;
        gmask    = sum_wr ? bus_wdata[NUM_PORTS-1:0] : '1;
        sum_base = sum_wr ? (sum_q & ~bus_wdata[NUM_PORTS-1:0]) : sum_q;
        sum_n    = sum_base;
        fire_vec = '0;
        leg_set  = 1'b0;
        leg_clr  = 1'b0;

        for (int i = 0; i < NUM_PORTS; i++) begin
            if (run_chk[i] && pend_nx[i]) begin
                if (has_own_vec(i, NUM_PORTS, NUM_VEC)) begin
                    sum_n[i] = 1'b1;
                    for (int v = 0; v < NUM_VEC; v++)
                        if (gie_n && v == i) fire_vec[v] = 1'b1;
                end else if (!sum_base[i]) begin
                    sum_n[i] = 1'b1;
                    if (gie_n) begin
                        if (NUM_VEC == 0) leg_set = 1'b1;
                        for (int v = 0; v < NUM_VEC; v++)
                            if (v == NUM_VEC - 1) fire_vec[v] = 1'b1;
                    end
                end
            end
        end

        if (reeval) begin
            sum_n = sum_n | pend_nx;
            if (sum_n == '0 || !gie_n) begin
                leg_clr = 1'b1;
            end else if (NUM_VEC == 0) begin
                leg_set = 1'b1;
            end else begin
                for (int v = 0; v < NUM_VEC; v++)
                    if (|(cover_mask(v) & gmask) && |(sum_n & gmask))
                        fire_vec[v] = 1'b1;
            end
        end

        legacy_n = leg_clr ? 1'b0 : (leg_set ? 1'b1 : legacy_q);
    end

    always_ff @(posedge clk) begin
        if (blk_rst) begin
            gie_q    <= 1'b0;
            sum_q    <= '0;
            legacy_q <= 1'b0;
        end else begin
            gie_q    <= gie_n;
            sum_q    <= sum_n;
            legacy_q <= legacy_n;
        end
    end

    assign legacy_irq = legacy_q;

    hba_vec_queue #(.NUM_VEC(NUM_VEC)) u_queue (
        .clk      (clk),
        .rst      (blk_rst),
        .fire_in  (fire_vec),
        .msg_valid(msg_valid),
        .msg_index(msg_index)
    );

    always_comb begin
        bus_rdata = '0;
        if (dec.hit) begin
            case (dec.kind)
                REG_CTRL:  bus_rdata = (32'(ADV) << CTRL_ADV_LSB) | (32'(gie_q) << CTRL_IE_BIT);
                REG_SUM:   bus_rdata = 32'(sum_q);
                REG_PSTAT: bus_rdata = stat_flat[int'(dec.port)*REG_W +: REG_W];
                REG_PEN:   bus_rdata = en_flat[int'(dec.port)*REG_W +: REG_W];
                default:   bus_rdata = '0;
            endcase
        end
    end

    // R1
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_sum_chk
        sum_rise_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(sum_q[i]) |-> pend_now[i]);
    end

    // R9
    legacy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(legacy_q) |-> gie_q);

    // R8
    host_reset_chk: assert property (@(posedge clk) disable iff (rst)
        host_rst |=> (sum_q == '0 && !legacy_q && !msg_valid && !gie_q));

endmodule

// File: tb/hba_irq_agg_tb.sv
module hba_irq_agg_tb;
    import hba_irq_pkg::*;

    localparam int DP = 6;
    localparam int DV = 4;
    localparam int LP = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [7:0]         d_addr = '0, l_addr = '0;
    logic [31:0]        d_wdata = '0, l_wdata = '0;
    logic               d_we = 1'b0, l_we = 1'b0;
    logic [31:0]        d_rdata, l_rdata;
    logic [DP-1:0]      d_stb = '0;
    logic [LP-1:0]      l_stb = '0;
    logic [DP*32-1:0]   d_bits = '0;
    logic [LP*32-1:0]   l_bits = '0;
    logic               d_leg, l_leg, d_mv, l_mv;
    logic [3:0]         d_mi, l_mi;

    hba_irq_agg #(.NUM_PORTS(DP), .NUM_VEC(DV), .ADDR_W(8)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(d_addr), .bus_wdata(d_wdata), .bus_we(d_we),
        .bus_rdata(d_rdata), .evt_stb(d_stb), .evt_bits(d_bits),
        .legacy_irq(d_leg), .msg_valid(d_mv), .msg_index(d_mi));

    hba_irq_agg #(.NUM_PORTS(LP), .NUM_VEC(0), .ADDR_W(8)) u_leg (
        .clk(clk), .rst(rst), .bus_addr(l_addr), .bus_wdata(l_wdata), .bus_we(l_we),
        .bus_rdata(l_rdata), .evt_stb(l_stb), .evt_bits(l_bits),
        .legacy_irq(l_leg), .msg_valid(l_mv), .msg_index(l_mi));

    int checks = 0;
    int fails  = 0;
    int    exp_idx[$];
    string exp_tag[$];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic expect_vec(int idx, string tag);
        exp_idx.push_back(idx);
        exp_tag.push_back(tag);
    endtask

    // Scoreboard monitor: every emitted message must match the queue head
    always @(negedge clk) begin
        if (!rst && d_mv) begin
            checks++;
            if (exp_idx.size() == 0) begin
                fails++;
                $display("FAIL unexpected message actual=%0d expected=none", d_mi);
            end else begin
                int e;
                string t;
                e = exp_idx.pop_front();
                t = exp_tag.pop_front();
                if (int'(d_mi) != e) begin
                    fails++;
                    $display("FAIL %s actual=%0d expected=%0d", t, d_mi, e);
                end
            end
        end
    end

    task automatic drain(string tag);
        repeat (8) @(negedge clk);
        check({tag, " queue drained"}, 32'(exp_idx.size()), 32'd0);
        exp_idx.delete();
        exp_tag.delete();
    endtask

    task automatic wr_d(int a, logic [31:0] v);
        d_addr = 8'(a); d_wdata = v; d_we = 1'b1;
        @(negedge clk);
        d_we = 1'b0;
    endtask

    task automatic wr_l(int a, logic [31:0] v);
        l_addr = 8'(a); l_wdata = v; l_we = 1'b1;
        @(negedge clk);
        l_we = 1'b0;
    endtask

    task automatic ev_d(int p, logic [31:0] b);
        d_stb = '0; d_stb[p] = 1'b1; d_bits[p*32 +: 32] = b;
        @(negedge clk);
        d_stb = '0;
    endtask

    task automatic ev_l(int p, logic [31:0] b);
        l_stb = '0; l_stb[p] = 1'b1; l_bits[p*32 +: 32] = b;
        @(negedge clk);
        l_stb = '0;
    endtask

    task automatic rd_d(int a, logic [31:0] exp, string tag);
        d_addr = 8'(a);
        #2;
        check(tag, d_rdata, exp);
    endtask

    task automatic rd_l(int a, logic [31:0] exp, string tag);
        l_addr = 8'(a);
        #2;
        check(tag, l_rdata, exp);
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        check("R8 reset legacy", 32'(d_leg), 0);
        check("R8 reset msg_valid", 32'(d_mv), 0);
        rd_d(0, 32'h800, "R11 ctrl after reset (adv count 8)");
        rd_d(1, 32'h0, "R8 summary after reset");

        wr_d(0, 32'h2);
        drain("R8 enable with empty summary");
        rd_d(0, 32'h802, "R11 ctrl enable bit");

        wr_d(3, 32'hFFFF_FFFF);
        rd_d(3, 32'hFDC0_00FF, "R6 enable write mask");

        expect_vec(0, "R4 port0 first event");
        ev_d(0, 32'h1);
        drain("R4 port0 first event");
        rd_d(1, 32'h1, "R1 summary bit0");

        ev_d(0, 32'h1);
        drain("R3 repeated bit no message");
        rd_d(2, 32'h1, "R3 port0 status");

        expect_vec(0, "R4 dedicated fires with summary set");
        ev_d(0, 32'h2);
        drain("R4 dedicated second event");
        rd_d(2, 32'h3, "R3 status merge");

        wr_d(9, 32'h1);
        wr_d(11, 32'h1);
        expect_vec(3, "R2 port3 to shared vector");
        ev_d(3, 32'h1);
        drain("R5 port3 rise");
        expect_vec(3, "R5 port4 own summary rise");
        ev_d(4, 32'h1);
        drain("R5 port4 rise");
        ev_d(3, 32'h2);
        drain("R5 shared no refire while summary set");

        ev_d(1, 32'h4);
        drain("R1 masked port no message");
        rd_d(4, 32'h4, "R1 masked port status stored");
        rd_d(1, 32'h19, "R1 summary ignores masked port");

        expect_vec(3, "R7 narrow mask shared vector");
        wr_d(1, 32'h8);
        drain("R7 narrow mask");
        rd_d(1, 32'h19, "R7 pending port merged back");

        expect_vec(0, "R10 order 0");
        expect_vec(1, "R10 order 1");
        expect_vec(2, "R10 order 2");
        expect_vec(3, "R10 order 3");
        wr_d(1, 32'h0F);
        drain("R10 ascending drain");

        wr_d(2, 32'h3);
        wr_d(8, 32'h3);
        wr_d(10, 32'h1);
        wr_d(1, 32'h3F);
        drain("R7 nothing pending no message");
        rd_d(1, 32'h0, "R7 summary cleared");

        ev_d(2, 32'h1);
        drain("R1 port2 masked");
        expect_vec(2, "R6 enable write reruns check");
        wr_d(7, 32'h1);
        drain("R6 enable write");
        rd_d(1, 32'h4, "R6 summary bit2");

        wr_d(0, 32'h0);
        ev_d(0, 32'h1);
        drain("R12 enable off no message");
        rd_d(1, 32'h5, "R12 summary still updated");

        expect_vec(0, "R8 enable reeval 0");
        expect_vec(1, "R8 enable reeval 1");
        expect_vec(2, "R8 enable reeval 2");
        expect_vec(3, "R8 enable reeval 3");
        wr_d(0, 32'h2);
        drain("R8 enable reeval");

        wr_d(0, 32'h3);
        check("R8 host reset msg_valid", 32'(d_mv), 0);
        rd_d(0, 32'h800, "R8 host reset ctrl");
        rd_d(1, 32'h0, "R8 host reset summary");
        rd_d(2, 32'h0, "R8 host reset status");
        rd_d(3, 32'h0, "R8 host reset enable");
        drain("R8 host reset");

        // Legacy-line instance
        rd_l(0, 32'h200, "R11 legacy instance adv count 2");
        wr_l(3, 32'h1);
        wr_l(0, 32'h2);
        check("R9 empty summary no legacy", 32'(l_leg), 0);
        ev_l(0, 32'h1);
        check("R9 legacy asserted", 32'(l_leg), 1);
        wr_l(2, 32'h1);
        check("R9 status clear keeps legacy", 32'(l_leg), 1);
        wr_l(1, 32'h1);
        check("R9 summary clear drops legacy", 32'(l_leg), 0);
        wr_l(0, 32'h0);
        ev_l(0, 32'h1);
        check("R12 legacy held off", 32'(l_leg), 0);
        rd_l(1, 32'h1, "R12 legacy summary set");
        wr_l(0, 32'h2);
        check("R9 enable reeval asserts legacy", 32'(l_leg), 1);
        check("R9 no messages without vectors", 32'(l_mv), 0);

        report();
        $finish;
    end

endmodule